// File: doc/BRIEF.md
# Double-Rate Prefetch Data Path

This block sits between a single-rate internal data bus that carries 64-bit words and a 32-bit double-data-rate pin interface. It runs on a fast clock at twice the internal word rate, so each internal word period is two fast cycles. A phase flag marks the first fast cycle of each word period, and internal-side sampling happens only on that cycle.

On the transmit side a burst start splits each 64-bit word into two 32-bit beats. The low half goes out first and the high half second. Before the first beat, the block drives the data strobe low for one word period. While data is out, a strobe flop clocked on the opposite edge of the fast clock toggles in the middle of every beat, so the strobe is centred in each data eye. When the last beat ends, the strobe and the data are released together.

On the receive side the memory returns a strobe whose edges coincide with the data changes. The block takes one beat on every strobe transition inside a read window and pairs the beats back into 64-bit words. It stops taking beats at the programmed burst length, and it flags a window that closes on an unpaired beat.

Top module: `ddr2n_phy`

## Requirements
- R1: `core_tick` is 1 in the first fast cycle after reset release and then alternates every fast cycle. `wr_go` and `wr_word` are sampled only at edges where `core_tick` is 1.
- R2: After an accepted `wr_go`, `dqs_oe` is 1 with the strobe low for two fast cycles before the first beat, while `dq_oe` stays 0.
- R3: Each 64-bit write word leaves on `dq_out` as two beats: bits 31:0 in the first fast cycle and bits 63:32 in the second.
- R4: During a write, `dqs_out` changes at the falling edge of the fast clock. It goes to 1 in the middle of the low beat and to 0 in the middle of the high beat. It is 0 at all other times.
- R5: `burst_sel` sets the number of beats: 0 gives 2, 1 gives 4, and 2 or 3 give 8. A burst pulls beats/2 words. `wr_pull` is 1 during each fast cycle whose closing edge samples `wr_word`.
- R6: `dq_oe` and `dqs_oe` both drop in the fast cycle after the last beat. A `wr_go` that arrives while a burst is in progress, or when `core_tick` is 0, is ignored.
- R7: While `rd_win` is 1, each change of `dqs_in` between consecutive fast-clock edges takes `dq_in` as a beat. The even-numbered beats (counting from 0) become the low half of a word and the odd-numbered beats the high half. One cycle after each odd beat is taken, `rd_valid` pulses with `rd_word = {odd beat, even beat}`.
- R8: When `rd_win` falls and an odd number of beats was taken in that window, `rd_err` pulses for one cycle. Otherwise `rd_err` stays 0.
- R9: Strobe changes with `rd_win` at 0 are ignored, and so are beats beyond the burst length that `burst_sel` selected when the window opened.
- R10: While `rst` is held, `dq_oe`, `dqs_oe`, `dqs_out`, `wr_pull`, `rd_valid` and `rd_err` are 0 and `core_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the internal word rate |
| rst | input | 1 | Synchronous active-high reset |
| core_tick | output | 1 | High in the first fast cycle of each word period |
| wr_go | input | 1 | Start a write burst |
| burst_sel | input | 2 | Burst length code |
| wr_word | input | 64 | Internal write word |
| wr_pull | output | 1 | Current `wr_word` is taken at the next edge |
| dq_out | output | 32 | Write beat to the pins |
| dq_oe | output | 1 | Write data drive enable |
| dqs_out | output | 1 | Write strobe, centred in each beat |
| dqs_oe | output | 1 | Write strobe drive enable |
| rd_win | input | 1 | Read burst window |
| dq_in | input | 32 | Read beat from the pins |
| dqs_in | input | 1 | Read strobe from the memory, edge-aligned |
| rd_valid | output | 1 | Reassembled read word valid |
| rd_word | output | 64 | Reassembled read word |
| rd_err | output | 1 | Window closed on an unpaired beat |

## Verification
Write bursts are run at every burst code, using counting, alternating-bit and walking-one word patterns. A swapped half, a lost word or a wrong beat count therefore shows up as a data mismatch rather than as a coincidental match. Starts arrive on non-core cycles and in the middle of a burst, which separates a correct idle check from a start that is accepted too eagerly. Read windows carry exact, short, odd and over-long strobe trains, plus toggles outside any window. These separate correct pairing, the length cap, the odd-close flag and window gating.

// File: rtl/ddr2n_pkg.sv
package ddr2n_pkg;
  localparam int BCNT_W = 4;

  typedef enum logic [1:0] {W_IDLE, W_PRE, W_DATA} wr_st_e;

  // Beat count for a burst code: 0 -> 2, 1 -> 4, otherwise 8.
  function automatic logic [BCNT_W-1:0] burst_beats(input logic [1:0] code);
    case (code)
      2'd0:    return BCNT_W'(2);
      2'd1:    return BCNT_W'(4);
      default: return BCNT_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/ddr2n_phase.sv
module ddr2n_phase (
  input  logic clk,
  input  logic rst,
  output logic core
);
  logic ph;

  always_ff @(posedge clk) begin
    if (rst) ph <= 1'b0;
    else     ph <= ~ph;
  end

  assign core = ~ph;
endmodule

// File: rtl/ddr2n_wr_path.sv
module ddr2n_wr_path
  import ddr2n_pkg::*;
#(
  parameter int DQ_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core,
  input  logic              go,
  input  logic [1:0]        sel,
  input  logic [2*DQ_W-1:0] word,
  output logic              pull,
  output logic [DQ_W-1:0]   dq,
  output logic              dq_oe,
  output logic              dqs,
  output logic              dqs_oe
);
  wr_st_e            st;
  logic              beat_hi;
  logic [BCNT_W-1:0] left;
  logic [DQ_W-1:0]   hi_buf;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= W_IDLE;
      beat_hi <= 1'b0;
      left    <= '0;
      hi_buf  <= '0;
      dq      <= '0;
    end else begin
      case (st)
        W_IDLE: if (go && core) begin
          st   <= W_PRE;
          left <= burst_beats(sel) >> 1;
        end
        W_PRE: if (core) begin
          st      <= W_DATA;
          dq      <= word[DQ_W-1:0];
          hi_buf  <= word[2*DQ_W-1:DQ_W];
          beat_hi <= 1'b0;
          left    <= left - 1'b1;
        end
        W_DATA: begin
          if (!beat_hi) begin
            dq      <= hi_buf;
            beat_hi <= 1'b1;
          end else if (left != '0) begin
            dq      <= word[DQ_W-1:0];
            hi_buf  <= word[2*DQ_W-1:DQ_W];
            beat_hi <= 1'b0;
            left    <= left - 1'b1;
          end else begin
            st      <= W_IDLE;
            beat_hi <= 1'b0;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  // Opposite-edge flop places strobe transitions mid-beat.
  always_ff @(negedge clk) begin
    if (rst) dqs <= 1'b0;
    else     dqs <= (st == W_DATA) && !beat_hi;
  end

  assign pull   = core && ((st == W_PRE) || (st == W_DATA && beat_hi && left != '0));
  assign dq_oe  = (st == W_DATA);
  assign dqs_oe = (st != W_IDLE);
endmodule

// File: rtl/ddr2n_rd_path.sv
module ddr2n_rd_path
  import ddr2n_pkg::*;
#(
  parameter int DQ_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win,
  input  logic [1:0]        sel,
  input  logic [DQ_W-1:0]   dq,
  input  logic              dqs,
  output logic              valid,
  output logic [2*DQ_W-1:0] word,
  output logic              err
);
  logic              dqs_q, win_q;
  logic [BCNT_W-1:0] cnt, lim, cnt_base, lim_base;
  logic [DQ_W-1:0]   lo_buf;
  logic              win_rise, take;

  always_comb begin
    win_rise = win && !win_q;
    cnt_base = win_rise ? '0 : cnt;
    lim_base = win_rise ? burst_beats(sel) : lim;
    take     = win && (dqs != dqs_q) && (cnt_base < lim_base);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dqs_q  <= 1'b0;
      win_q  <= 1'b0;
      cnt    <= '0;
      lim    <= '0;
      lo_buf <= '0;
      valid  <= 1'b0;
      word   <= '0;
      err    <= 1'b0;
    end else begin
      dqs_q <= dqs;
      win_q <= win;
      lim   <= lim_base;
      cnt   <= take ? cnt_base + 1'b1 : cnt_base;
      valid <= take && cnt_base[0];
      if (take && !cnt_base[0]) lo_buf <= dq;
      if (take && cnt_base[0])  word   <= {dq, lo_buf};
      err   <= !win && win_q && cnt[0];
    end
  end
endmodule

// File: rtl/ddr2n_phy.sv
module ddr2n_phy #(
  parameter int DQ_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic              core_tick,
  input  logic              wr_go,
  input  logic [1:0]        burst_sel,
  input  logic [2*DQ_W-1:0] wr_word,
  output logic              wr_pull,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              dqs_out,
  output logic              dqs_oe,
  input  logic              rd_win,
  input  logic [DQ_W-1:0]   dq_in,
  input  logic              dqs_in,
  output logic              rd_valid,
  output logic [2*DQ_W-1:0] rd_word,
  output logic              rd_err
);
  ddr2n_phase u_phase (.clk(clk), .rst(rst), .core(core_tick));

  ddr2n_wr_path #(.DQ_W(DQ_W)) u_wr (
    .clk(clk), .rst(rst), .core(core_tick), .go(wr_go), .sel(burst_sel),
    .word(wr_word), .pull(wr_pull), .dq(dq_out), .dq_oe(dq_oe),
    .dqs(dqs_out), .dqs_oe(dqs_oe)
  );

  ddr2n_rd_path #(.DQ_W(DQ_W)) u_rd (
    .clk(clk), .rst(rst), .win(rd_win), .sel(burst_sel), .dq(dq_in),
    .dqs(dqs_in), .valid(rd_valid), .word(rd_word), .err(rd_err)
  );
endmodule

// File: rtl/ddr2n_phy_chk.sv
module ddr2n_phy_chk (
  input logic clk,
  input logic rst,
  input logic core_tick,
  input logic wr_pull,
  input logic dq_oe,
  input logic dqs_out,
  input logic dqs_oe,
  input logic rd_win,
  input logic rd_err
);
  p_tick_alternates_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> core_tick != $past(core_tick));

  p_preamble_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> $past(dqs_oe) && $past(dqs_oe, 2) && !$past(dq_oe, 2));

  p_strobe_in_data_r4: assert property (@(posedge clk) disable iff (rst)
    dqs_out |-> dq_oe);

  p_pull_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
    wr_pull |-> core_tick);

  p_data_under_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> dqs_oe);

  p_err_after_close_r8: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> !$past(rd_win) && $past(rd_win, 2));
endmodule

bind ddr2n_phy ddr2n_phy_chk u_chk (.*);

// File: tb/ddr2n_phy_test.sv
module ddr2n_phy_test;
  localparam int PERIOD = 10;

  typedef struct {
    logic [31:0] dq;
    bit dqoe, dqsoe, dqs, pull;
  } ent_t;

  logic        clk = 0, rst = 1;
  logic        wr_go = 0, rd_win = 0, dqs_in = 0;
  logic [1:0]  burst_sel = 0;
  logic [63:0] wr_word = 0;
  logic [31:0] dq_in = 0;
  logic        core_tick, wr_pull, dq_oe, dqs_out, dqs_oe, rd_valid, rd_err;
  logic [31:0] dq_out;
  logic [63:0] rd_word;

  ddr2n_phy uut (.*);

  always #(PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  ent_t        tq[$];
  logic [63:0] wq[$];
  ent_t        cur = '{dq: 0, dqoe: 0, dqsoe: 0, dqs: 0, pull: 0};
  bit          m_ph = 0;
  bit          r_pdqs = 0, r_pwin = 0;
  int          r_cnt = 0, r_lim = 0;
  logic [31:0] r_lo = 0;

  function automatic int beats(input logic [1:0] s);
    return (s == 0) ? 2 : (s == 1) ? 4 : 8;
  endfunction

  function automatic void chk(input bit ok, input string req,
                              input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endfunction

  function automatic void model_edge();
    ent_t prev = cur;
    ent_t e;
    bit ev = 0, ee = 0;
    logic [63:0] ew = 0;
    int nw;
    if (prev.pull && wq.size() > 0) void'(wq.pop_front());
    if (tq.size() > 0) cur = tq.pop_front();
    else cur = '{dq: 0, dqoe: 0, dqsoe: 0, dqs: 0, pull: 0};
    if (m_ph == 0 && !prev.dqsoe && wr_go) begin
      nw = beats(burst_sel) / 2;
      cur = '{dq: 0, dqoe: 0, dqsoe: 1, dqs: 0, pull: 0};
      tq.push_back('{dq: 0, dqoe: 0, dqsoe: 1, dqs: 0, pull: 1});
      for (int j = 0; j < nw; j++) begin
        e = '{dq: wq[j][31:0], dqoe: 1, dqsoe: 1, dqs: 1, pull: 0};
        tq.push_back(e);
        e = '{dq: wq[j][63:32], dqoe: 1, dqsoe: 1, dqs: 0, pull: (j < nw - 1)};
        tq.push_back(e);
      end
    end
    m_ph = ~m_ph;
    // read side
    if (rd_win && !r_pwin) begin r_cnt = 0; r_lim = beats(burst_sel); end
    if (!rd_win && r_pwin) ee = r_cnt[0];
    if (rd_win && dqs_in != r_pdqs && r_cnt < r_lim) begin
      if (r_cnt % 2 == 0) r_lo = dq_in;
      else begin ev = 1; ew = {dq_in, r_lo}; end
      r_cnt++;
    end
    r_pdqs = dqs_in;
    r_pwin = rd_win;
    // compare
    chk(core_tick == (m_ph == 0), "R1", core_tick, m_ph == 0);
    chk(wr_pull == cur.pull, "R5", wr_pull, cur.pull);
    chk(dqs_oe == cur.dqsoe, "R2", dqs_oe, cur.dqsoe);
    chk(dq_oe == cur.dqoe, "R6", dq_oe, cur.dqoe);
    if (cur.dqoe) chk(dq_out == cur.dq, "R3", dq_out, cur.dq);
    chk(rd_valid == ev, "R7 R9", rd_valid, ev);
    if (ev) chk(rd_word == ew, "R7", rd_word, ew);
    chk(rd_err == ee, "R8", rd_err, ee);
  endfunction

  task automatic step();
    @(negedge clk); #1;
    if (!rst) chk(dqs_out == cur.dqs, "R4", dqs_out, cur.dqs);
    wr_word = (wq.size() > 0) ? wq[0] : 64'h0;
    @(posedge clk); #1;
    if (!rst) model_edge();
  endtask

  function automatic logic [63:0] mk_word(input int mode, input int j);
    case (mode)
      0: return {32'h1000_0000 + 32'(2*j+1), 32'h1000_0000 + 32'(2*j)};
      1: return (j % 2) ? 64'h5555_5555_AAAA_AAAA : 64'hAAAA_AAAA_5555_5555;
      default: return 64'h1 << (j * 9 + 3);
    endcase
  endfunction

  task automatic write_burst(input logic [1:0] s, input int mode);
    while (m_ph != 0 || cur.dqsoe) step();
    for (int j = 0; j < beats(s) / 2; j++) wq.push_back(mk_word(mode, j));
    burst_sel = s; wr_go = 1;
    step();
    wr_go = 0;
    while (tq.size() > 0 || cur.dqsoe) step();
    step();
  endtask

  task automatic read_burst(input logic [1:0] s, input int n, input logic [31:0] base);
    burst_sel = s; rd_win = 1; dqs_in = 0;
    step();
    for (int k = 0; k < n; k++) begin
      dqs_in = ~dqs_in; dq_in = base + 32'(k * 32'h0101);
      step();
    end
    rd_win = 0; dqs_in = 0;
    step(); step(); step();
  endtask

  initial begin
    repeat (3) step();
    // R10 reset state
    chk(dq_oe == 0 && dqs_oe == 0, "R10", {dq_oe, dqs_oe}, 0);
    chk(dqs_out == 0 && wr_pull == 0, "R10", {dqs_out, wr_pull}, 0);
    chk(rd_valid == 0 && rd_err == 0, "R10", {rd_valid, rd_err}, 0);
    chk(core_tick == 1, "R10", core_tick, 1);
    rst = 0;
    repeat (3) step();
    // R3 R5 writes at every burst code
    write_burst(2'd0, 0);
    write_burst(2'd1, 1);
    write_burst(2'd2, 2);
    write_burst(2'd3, 0);
    // R6 start on a non-core cycle is ignored
    while (m_ph != 1) step();
    wr_go = 1; step(); wr_go = 0;
    repeat (4) step();
    // R6 start in the middle of a burst is ignored
    while (m_ph != 0) step();
    for (int j = 0; j < 2; j++) wq.push_back(mk_word(1, j + 5));
    burst_sel = 2'd1; wr_go = 1; step(); wr_go = 0;
    repeat (3) step();
    wr_go = 1; step(); step(); wr_go = 0;
    while (tq.size() > 0 || cur.dqsoe) step();
    repeat (2) step();
    // R7 reads at each length
    read_burst(2'd0, 2, 32'hA000_0000);
    read_burst(2'd1, 4, 32'hB000_0010);
    read_burst(2'd2, 8, 32'hC000_0100);
    read_burst(2'd3, 8, 32'hD000_1000);
    // R8 odd close
    read_burst(2'd1, 3, 32'hE000_0001);
    read_burst(2'd2, 1, 32'hE100_0001);
    // R9 beats beyond the length, and toggles outside a window
    read_burst(2'd0, 5, 32'hF000_0002);
    for (int k = 0; k < 4; k++) begin
      dqs_in = ~dqs_in; dq_in = 32'h7777_0000 + k; step();
    end
    dqs_in = 0; repeat (2) step();
    read_burst(2'd1, 4, 32'h1234_5678);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule